// File: doc/BRIEF.md
# Trace Event Router

This block sits beside a trace collection unit. It takes trigger and marker events from the local logic and from the global fabric and decides, under two small policy fields, what each one does. A local event may be sent on to the fabric, written into the trace stream, or used to start and stop tracing. It also gathers a set of debug stop sources, each with its own enable, into one stop request. The request ends tracing.

Event inputs are qualified on their rising edge, so a held level counts as one event. Every event, stop source and control field is sampled at a clock edge. At that same edge the output strobes and the trace state register update. Tracing runs from idle to tracing to stopped. The stopped state is left only through reset.

Top module: `trc_evt_router`

## Requirements
- R1: With trigger policy `trg_ctl_i`=00, local triggers are never forwarded. A rising edge of local or of global start moves idle to tracing. A rising edge of local or of global stop moves tracing to stopped. A local start or stop edge seen while tracing gives one `ins_trig_o` pulse, and global triggers never do.
- R2: With trigger policy 01, local triggers are not forwarded and are inserted while tracing. Only local start and stop change the state, and global start or stop edges have no effect on `trc_state_o`.
- R3: With trigger policy 10 or 11, each local start or stop edge gives one `fwd_trig_o` pulse in any state, and `ins_trig_o` stays 0. Only global start and stop change the state, and local edges leave it unchanged.
- R4: With marker policy `mrk_ctl_i`=00, neither marker is forwarded, and both local and global marker edges pulse `ins_mark_o` while tracing. With 01, only local marker edges are inserted.
- R5: With marker policy 10, each local marker edge pulses `fwd_mark_o` and only global markers are inserted. With 11, local markers are forwarded and nothing is inserted.
- R6: `trc_state_o` encodes idle=00, tracing=01, stopped=10. Start events are ignored outside idle. Stop triggers and stop sources are ignored in idle. Stopped is held until reset.
- R7: While tracing, a high chip debug trigger, core debug trigger or auxiliary stop input whose own enable bit is 1 moves the state to stopped at the next edge. With the enable at 0 that input has no effect.
- R8: With `en_run_fall_i`=1, a 1-to-0 change of `run_i` while tracing moves the state to stopped. A 0-to-1 change has no effect, and so does any change while the enable is 0.
- R9: The checkstop stop enable is active low. With `xstop_dis_i`=0, a high `xstop_i` stops tracing. With `xstop_dis_i`=1, checkstop is ignored. Software is expected to leave this bit at 1 by default.
- R10: Insertion strobes occur only when the state was tracing at the sampling edge. Each strobe lasts one cycle per input rising edge, even when the input stays high. All strobes and state changes appear at the first clock edge that samples the event.
- R11: During and right after reset the state is idle and all four strobes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trg_ctl_i | input | 2 | Trigger routing policy |
| mrk_ctl_i | input | 2 | Marker routing policy |
| loc_start_i | input | 1 | Local start trigger |
| loc_stop_i | input | 1 | Local stop trigger |
| glb_start_i | input | 1 | Global start trigger from fabric |
| glb_stop_i | input | 1 | Global stop trigger from fabric |
| loc_mark_i | input | 1 | Local marker event |
| glb_mark_i | input | 1 | Global marker event from fabric |
| chip_dbg_i | input | N_CHIP_DBG | Chip debug trigger levels |
| core_dbg_i | input | N_CORE_DBG | Core debug trigger levels |
| run_i | input | 1 | Trace-run level |
| aux_stop_i | input | 1 | Stop request from a secondary controller |
| xstop_i | input | 1 | Checkstop level |
| en_chip_dbg_i | input | N_CHIP_DBG | Per-source chip debug stop enables |
| en_core_dbg_i | input | N_CORE_DBG | Per-source core debug stop enables |
| en_run_fall_i | input | 1 | Enable stop on run falling edge |
| en_aux_i | input | 1 | Enable auxiliary stop |
| xstop_dis_i | input | 1 | Checkstop stop disable (0 enables) |
| fwd_trig_o | output | 1 | Local trigger forward strobe |
| fwd_mark_o | output | 1 | Local marker forward strobe |
| ins_trig_o | output | 1 | Trigger insert-into-trace strobe |
| ins_mark_o | output | 1 | Marker insert-into-trace strobe |
| trc_state_o | output | 2 | Trace state |

## Verification
The hardest case to reach is a stop source that is active but has no effect: an enabled source while idle, a disabled source while tracing, or a rising run edge. Each such case can only be seen as the absence of a transition. The stimulus for each case first brings the state to tracing with a local start under policy 00. It then holds the source high with its enable off and confirms that tracing continues. Only after that does it set the enable and expect the stop on the next edge. The run test raises `run_i` before tracing starts, so the registered copy is 1 when the level drops.

// File: rtl/trc_evt_pkg.sv
package trc_evt_pkg;
   typedef enum logic [1:0] {
      TS_IDLE    = 2'b00,
      TS_TRACING = 2'b01,
      TS_STOPPED = 2'b10
   } trc_state_e;

   localparam logic [1:0] TRG_BOTH_CTL  = 2'b00;
   localparam logic [1:0] TRG_LOCAL_CTL = 2'b01;

   localparam logic [1:0] MRK_INS_BOTH  = 2'b00;
   localparam logic [1:0] MRK_INS_LOCAL = 2'b01;
   localparam logic [1:0] MRK_INS_GLB   = 2'b10;

   typedef struct packed {
      logic fwd;
      logic ins;
   } route_t;
endpackage

// File: rtl/trc_edge_qual.sv
module trc_edge_qual #(
   parameter int W = 6
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] lvl_i,
   output logic [W-1:0] rise_o
);
   logic [W-1:0] lvl_q;

   for (genvar g = 0; g < W; g++) begin : g_bit
      always_ff @(posedge clk) begin
         if (!rst_n) lvl_q[g] <= 1'b0;
         else        lvl_q[g] <= lvl_i[g];
      end
      assign rise_o[g] = lvl_i[g] & ~lvl_q[g];
   end
endmodule

// File: rtl/trc_trig_policy.sv
module trc_trig_policy
   import trc_evt_pkg::*;
(
   input  logic [1:0] ctl_i,
   input  logic       ls_i,
   input  logic       lp_i,
   input  logic       gs_i,
   input  logic       gp_i,
   output route_t     loc_route_o,
   output logic       go_o,
   output logic       halt_o
);
   logic any_loc;
   assign any_loc = ls_i | lp_i;

   always_comb begin
      loc_route_o.fwd = ctl_i[1] & any_loc;
      loc_route_o.ins = ~ctl_i[1] & any_loc;
      unique case (ctl_i)
         TRG_BOTH_CTL: begin
            go_o   = ls_i | gs_i;
            halt_o = lp_i | gp_i;
         end
         TRG_LOCAL_CTL: begin
            go_o   = ls_i;
            halt_o = lp_i;
         end
         default: begin
            go_o   = gs_i;
            halt_o = gp_i;
         end
      endcase
   end
endmodule

// File: rtl/trc_mark_policy.sv
module trc_mark_policy
   import trc_evt_pkg::*;
(
   input  logic [1:0] ctl_i,
   input  logic       lm_i,
   input  logic       gm_i,
   output route_t     route_o
);
   always_comb begin
      route_o.fwd = ctl_i[1] & lm_i;
      unique case (ctl_i)
         MRK_INS_BOTH:  route_o.ins = lm_i | gm_i;
         MRK_INS_LOCAL: route_o.ins = lm_i;
         MRK_INS_GLB:   route_o.ins = gm_i;
         default:       route_o.ins = 1'b0;
      endcase
   end
endmodule

// File: rtl/trc_stop_gather.sv
module trc_stop_gather #(
   parameter int N_CHIP = 2,
   parameter int N_CORE = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_CHIP-1:0] chip_i,
   input  logic [N_CORE-1:0] core_i,
   input  logic              run_i,
   input  logic              aux_i,
   input  logic              xstop_i,
   input  logic [N_CHIP-1:0] en_chip_i,
   input  logic [N_CORE-1:0] en_core_i,
   input  logic              en_run_fall_i,
   input  logic              en_aux_i,
   input  logic              xstop_dis_i,
   output logic              stop_o
);
   localparam int N_SRC = N_CHIP + N_CORE + 3;

   logic             run_q;
   logic             run_fall;
   logic [N_SRC-1:0] hit;

   always_ff @(posedge clk) begin
      if (!rst_n) run_q <= 1'b0;
      else        run_q <= run_i;
   end
   assign run_fall = run_q & ~run_i;

   for (genvar c = 0; c < N_CHIP; c++) begin : g_chip
      assign hit[c] = chip_i[c] & en_chip_i[c];
   end
   for (genvar k = 0; k < N_CORE; k++) begin : g_core
      assign hit[N_CHIP+k] = core_i[k] & en_core_i[k];
   end
   assign hit[N_SRC-3] = run_fall & en_run_fall_i;
   assign hit[N_SRC-2] = aux_i & en_aux_i;
   assign hit[N_SRC-1] = xstop_i & ~xstop_dis_i;

   assign stop_o = |hit;
endmodule

// File: rtl/trc_evt_router.sv
module trc_evt_router
   import trc_evt_pkg::*;
#(
   parameter int N_CHIP_DBG = 2,
   parameter int N_CORE_DBG = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [1:0]            trg_ctl_i,
   input  logic [1:0]            mrk_ctl_i,
   input  logic                  loc_start_i,
   input  logic                  loc_stop_i,
   input  logic                  glb_start_i,
   input  logic                  glb_stop_i,
   input  logic                  loc_mark_i,
   input  logic                  glb_mark_i,
   input  logic [N_CHIP_DBG-1:0] chip_dbg_i,
   input  logic [N_CORE_DBG-1:0] core_dbg_i,
   input  logic                  run_i,
   input  logic                  aux_stop_i,
   input  logic                  xstop_i,
   input  logic [N_CHIP_DBG-1:0] en_chip_dbg_i,
   input  logic [N_CORE_DBG-1:0] en_core_dbg_i,
   input  logic                  en_run_fall_i,
   input  logic                  en_aux_i,
   input  logic                  xstop_dis_i,
   output logic                  fwd_trig_o,
   output logic                  fwd_mark_o,
   output logic                  ins_trig_o,
   output logic                  ins_mark_o,
   output logic [1:0]            trc_state_o
);
   localparam int N_EV = 6;

   if (N_CHIP_DBG < 1 || N_CORE_DBG < 1) begin : g_bad_cfg
      $error("trc_evt_router: debug source counts must be at least 1");
   end

   logic [N_EV-1:0] ev_lvl, ev;
   route_t          trg_rt, mrk_rt;
   logic            go, halt, src_stop;
   trc_state_e      st_q, st_d;
   logic            tracing;

   assign ev_lvl = {glb_mark_i, loc_mark_i, glb_stop_i, glb_start_i,
                    loc_stop_i, loc_start_i};

   trc_edge_qual #(.W(N_EV)) u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .lvl_i (ev_lvl),
      .rise_o(ev)
   );

   trc_trig_policy u_trig (
      .ctl_i      (trg_ctl_i),
      .ls_i       (ev[0]),
      .lp_i       (ev[1]),
      .gs_i       (ev[2]),
      .gp_i       (ev[3]),
      .loc_route_o(trg_rt),
      .go_o       (go),
      .halt_o     (halt)
   );

   trc_mark_policy u_mark (
      .ctl_i  (mrk_ctl_i),
      .lm_i   (ev[4]),
      .gm_i   (ev[5]),
      .route_o(mrk_rt)
   );

   trc_stop_gather #(.N_CHIP(N_CHIP_DBG), .N_CORE(N_CORE_DBG)) u_stop (
      .clk          (clk),
      .rst_n        (rst_n),
      .chip_i       (chip_dbg_i),
      .core_i       (core_dbg_i),
      .run_i        (run_i),
      .aux_i        (aux_stop_i),
      .xstop_i      (xstop_i),
      .en_chip_i    (en_chip_dbg_i),
      .en_core_i    (en_core_dbg_i),
      .en_run_fall_i(en_run_fall_i),
      .en_aux_i     (en_aux_i),
      .xstop_dis_i  (xstop_dis_i),
      .stop_o       (src_stop)
   );

   assign tracing = (st_q == TS_TRACING);

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         TS_IDLE:    if (go) st_d = TS_TRACING;
         TS_TRACING: if (halt || src_stop) st_d = TS_STOPPED;
         default:    st_d = TS_STOPPED;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q       <= TS_IDLE;
         fwd_trig_o <= 1'b0;
         fwd_mark_o <= 1'b0;
         ins_trig_o <= 1'b0;
         ins_mark_o <= 1'b0;
      end else begin
         st_q       <= st_d;
         fwd_trig_o <= trg_rt.fwd;
         fwd_mark_o <= mrk_rt.fwd;
         ins_trig_o <= trg_rt.ins & tracing;
         ins_mark_o <= mrk_rt.ins & tracing;
      end
   end

   assign trc_state_o = st_q;
endmodule

// File: rtl/trc_evt_router_chk.sv
module trc_evt_router_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [1:0] trg_ctl_i,
   input logic [1:0] mrk_ctl_i,
   input logic       fwd_trig_o,
   input logic       fwd_mark_o,
   input logic       ins_trig_o,
   input logic       ins_mark_o,
   input logic [1:0] trc_state_o
);
   AST_INS_WHILE_TRACING: assert property (@(posedge clk) disable iff (!rst_n)
      (ins_trig_o || ins_mark_o) |-> $past(trc_state_o) == 2'b01); // R10

   AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      trc_state_o == 2'b10 |=> trc_state_o == 2'b10); // R6

   AST_IDLE_NO_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
      trc_state_o == 2'b00 |=> trc_state_o != 2'b10); // R6

   AST_TRIG_FWD_POLICY: assert property (@(posedge clk) disable iff (!rst_n)
      fwd_trig_o |-> $past(trg_ctl_i[1])); // R3

   AST_TRIG_INS_POLICY: assert property (@(posedge clk) disable iff (!rst_n)
      ins_trig_o |-> !$past(trg_ctl_i[1])); // R1

   AST_MARK_FWD_POLICY: assert property (@(posedge clk) disable iff (!rst_n)
      fwd_mark_o |-> $past(mrk_ctl_i[1])); // R5

   AST_MARK_NONE_INS: assert property (@(posedge clk) disable iff (!rst_n)
      ins_mark_o |-> $past(mrk_ctl_i) != 2'b11); // R5

   AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      trc_state_o != 2'b11); // R6
endmodule

bind trc_evt_router trc_evt_router_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .trg_ctl_i  (trg_ctl_i),
   .mrk_ctl_i  (mrk_ctl_i),
   .fwd_trig_o (fwd_trig_o),
   .fwd_mark_o (fwd_mark_o),
   .ins_trig_o (ins_trig_o),
   .ins_mark_o (ins_mark_o),
   .trc_state_o(trc_state_o)
);

// File: tb/sim_trc_evt_router.sv
`timescale 1ns/1ps
module sim_trc_evt_router;
   localparam real CLK_P = 4.0;
   localparam logic [1:0] S_IDLE = 2'b00, S_TRC = 2'b01, S_STP = 2'b10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] trg_ctl = 2'b00, mrk_ctl = 2'b00;
   logic       loc_start = 0, loc_stop = 0, glb_start = 0, glb_stop = 0;
   logic       loc_mark = 0, glb_mark = 0;
   logic [1:0] chip_dbg = 0, core_dbg = 0, en_chip = 0, en_core = 0;
   logic       run = 0, aux_stop = 0, xstop = 0;
   logic       en_run_fall = 0, en_aux = 0, xstop_dis = 1;
   logic       fwd_trig, fwd_mark, ins_trig, ins_mark;
   logic [1:0] st;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   always #(CLK_P/2) clk = ~clk;

   trc_evt_router u0 (
      .clk(clk), .rst_n(rst_n), .trg_ctl_i(trg_ctl), .mrk_ctl_i(mrk_ctl),
      .loc_start_i(loc_start), .loc_stop_i(loc_stop),
      .glb_start_i(glb_start), .glb_stop_i(glb_stop),
      .loc_mark_i(loc_mark), .glb_mark_i(glb_mark),
      .chip_dbg_i(chip_dbg), .core_dbg_i(core_dbg), .run_i(run),
      .aux_stop_i(aux_stop), .xstop_i(xstop),
      .en_chip_dbg_i(en_chip), .en_core_dbg_i(en_core),
      .en_run_fall_i(en_run_fall), .en_aux_i(en_aux), .xstop_dis_i(xstop_dis),
      .fwd_trig_o(fwd_trig), .fwd_mark_o(fwd_mark),
      .ins_trig_o(ins_trig), .ins_mark_o(ins_mark), .trc_state_o(st)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic step;
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic do_reset;
      @(negedge clk);
      rst_n = 0;
      trg_ctl = 0; mrk_ctl = 0;
      loc_start = 0; loc_stop = 0; glb_start = 0; glb_stop = 0;
      loc_mark = 0; glb_mark = 0; chip_dbg = 0; core_dbg = 0;
      en_chip = 0; en_core = 0; run = 0; aux_stop = 0; xstop = 0;
      en_run_fall = 0; en_aux = 0; xstop_dis = 1;
      repeat (3) step;
      rst_n = 1;
   endtask

   task automatic enter_tracing;
      trg_ctl = 2'b00;
      loc_start = 1; step; loc_start = 0; step;
   endtask

   task automatic t_reset;
      @(negedge clk);
      rst_n = 0;
      loc_start = 1; loc_mark = 1;
      step;
      chk("R11 state in reset", st, S_IDLE);
      chk("R11 strobes in reset", {fwd_trig, fwd_mark, ins_trig, ins_mark}, 0);
      do_reset;
      step;
      chk("R11 state after reset", st, S_IDLE);
      chk("R11 strobes after reset", {fwd_trig, fwd_mark, ins_trig, ins_mark}, 0);
   endtask

   task automatic t_trig_both;
      do_reset;
      trg_ctl = 2'b00;
      loc_start = 1; step;
      chk("R1 local start begins tracing", st, S_TRC);
      chk("R1 no insert from idle", ins_trig, 0);
      chk("R1 no forward", fwd_trig, 0);
      loc_start = 0; step;
      loc_start = 1; step;
      chk("R1 local start inserted while tracing", ins_trig, 1);
      chk("R6 start ignored while tracing", st, S_TRC);
      loc_start = 0; step;
      chk("R10 insert strobe one cycle", ins_trig, 0);
      glb_stop = 1; step;
      chk("R1 global stop ends tracing", st, S_STP);
      chk("R1 global stop not inserted", ins_trig, 0);
      glb_stop = 0; step;
      do_reset;
      trg_ctl = 2'b00;
      glb_start = 1; step; glb_start = 0;
      chk("R1 global start begins tracing", st, S_TRC);
   endtask

   task automatic t_trig_local;
      do_reset;
      trg_ctl = 2'b01;
      glb_start = 1; step; glb_start = 0; step;
      chk("R2 global start ignored", st, S_IDLE);
      loc_start = 1; step; loc_start = 0;
      chk("R2 local start begins tracing", st, S_TRC);
      chk("R2 no forward", fwd_trig, 0);
      step;
      glb_stop = 1; step; glb_stop = 0; step;
      chk("R2 global stop ignored", st, S_TRC);
      loc_stop = 1; step; loc_stop = 0;
      chk("R2 local stop ends tracing", st, S_STP);
      chk("R2 local stop inserted", ins_trig, 1);
      step;
   endtask

   task automatic t_trig_global;
      do_reset;
      trg_ctl = 2'b10;
      loc_start = 1; step; loc_start = 0;
      chk("R3 local start forwarded in idle", fwd_trig, 1);
      chk("R3 local start does not control", st, S_IDLE);
      step;
      chk("R3 forward strobe one cycle", fwd_trig, 0);
      glb_start = 1; step; glb_start = 0; step;
      chk("R3 global start begins tracing", st, S_TRC);
      trg_ctl = 2'b11;
      loc_stop = 1; step; loc_stop = 0;
      chk("R3 local stop forwarded", fwd_trig, 1);
      chk("R3 local stop not inserted", ins_trig, 0);
      chk("R3 local stop does not control", st, S_TRC);
      step;
      glb_stop = 1; step; glb_stop = 0;
      chk("R3 global stop ends tracing", st, S_STP);
      step;
   endtask

   task automatic t_marks;
      for (int c = 0; c < 4; c++) begin
         do_reset;
         mrk_ctl = c[1:0];
         loc_mark = 1; step; loc_mark = 0;
         chk(c < 2 ? "R4 local marker in idle" : "R5 local marker in idle",
             {fwd_mark, ins_mark}, {c[1], 1'b0});
         step;
         enter_tracing;
         loc_mark = 1; step; loc_mark = 0;
         chk(c < 2 ? "R4 local marker routing" : "R5 local marker routing",
             {fwd_mark, ins_mark}, {c[1], (c == 0 || c == 1) ? 1'b1 : 1'b0});
         step;
         glb_mark = 1; step; glb_mark = 0;
         chk(c < 2 ? "R4 global marker routing" : "R5 global marker routing",
             {fwd_mark, ins_mark}, {1'b0, (c == 0 || c == 2) ? 1'b1 : 1'b0});
         step;
      end
   endtask

   task automatic t_held;
      do_reset;
      enter_tracing;
      mrk_ctl = 2'b00;
      loc_mark = 1; step;
      chk("R10 held marker first cycle", ins_mark, 1);
      step;
      chk("R10 held marker second cycle", ins_mark, 0);
      step;
      chk("R10 held marker third cycle", ins_mark, 0);
      loc_mark = 0; step;
   endtask

   task automatic set_src(input int k, input logic v);
      case (k)
         0: chip_dbg[0] = v;
         1: chip_dbg[1] = v;
         2: core_dbg[0] = v;
         3: core_dbg[1] = v;
         default: aux_stop = v;
      endcase
   endtask

   task automatic set_en(input int k, input logic v);
      case (k)
         0: en_chip[0] = v;
         1: en_chip[1] = v;
         2: en_core[0] = v;
         3: en_core[1] = v;
         default: en_aux = v;
      endcase
   endtask

   task automatic t_stop_sources;
      for (int k = 0; k < 5; k++) begin
         do_reset;
         set_src(k, 1); set_en(k, 1); step;
         chk("R6 enabled source ignored in idle", st, S_IDLE);
         set_en(k, 0);
         enter_tracing;
         step;
         chk("R7 disabled source ignored", st, S_TRC);
         set_en(k, 1); step;
         chk("R7 enabled source stops tracing", st, S_STP);
         set_src(k, 0); step;
         chk("R6 stopped held", st, S_STP);
      end
   endtask

   task automatic t_run;
      do_reset;
      run = 1; step;
      enter_tracing;
      run = 0; step; step;
      chk("R8 fall ignored when disabled", st, S_TRC);
      en_run_fall = 1;
      run = 1; step; step;
      chk("R8 rise has no effect", st, S_TRC);
      run = 0; step;
      chk("R8 falling edge stops tracing", st, S_STP);
   endtask

   task automatic t_xstop;
      do_reset;
      enter_tracing;
      xstop = 1; xstop_dis = 1; step; step;
      chk("R9 checkstop ignored when disable=1", st, S_TRC);
      xstop_dis = 0; step;
      chk("R9 checkstop stops when disable=0", st, S_STP);
      xstop = 0;
   endtask

   initial begin
      t_reset;
      t_trig_both;
      t_trig_local;
      t_trig_global;
      t_marks;
      t_held;
      t_stop_sources;
      t_run;
      t_xstop;
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule